// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status

This block receives asynchronous serial characters from a single line. A clock enable pulsing at sixteen times the bit rate paces it. The line first passes through a two-stage synchronizer. A falling edge seen while the receiver is idle opens a frame. Each bit slot then gets sixteen sample points, and the bit takes the majority value of the seventh, eighth and ninth samples. Decided data bits shift into an internal register, least significant bit first. At the ninth sample of the stop bit, the character moves to a holding register and the receiver goes idle, so it can lock onto the next start edge at once.

Next to the character, the block keeps a status set: data-ready, overrun, parity error, framing error and break. A read strobe for the data clears data-ready. A read strobe for the status clears the four error flags. Two request outputs serve an interrupt or DMA fabric. The receive request is a one-cycle pulse when data-ready goes from 0 to 1. The error request is a level that stays high while any error flag is set. Each request has its own enable input.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, rxData is 0, all five status flags are 0 and both request outputs are 0.
- R2: A frame starts only on a falling edge of the synchronized line while the receiver is idle. If the start bit's mid-bit majority is 1, the frame is dropped without touching any output.
- R3: Each bit is the majority of its 7th, 8th and 9th oversamples. One flipped sample among them does not change the bit, and two flipped samples do.
- R4: Data arrives least significant bit first. cfgLen selects the character length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits), and shorter characters are zero-extended in rxData.
- R5: The character is committed at the 9th oversample of the stop bit. With tick high on every clock, edge 1 is the first edge that samples the low line. data-ready is then set by edge 12 + 16·(1 + N + P), where N is the data length and P is 1 when parity is enabled.
- R6: With cfgParEn = 1, one parity bit follows the data. It is even parity when cfgParOdd = 0 and odd parity when cfgParOdd = 1. A mismatch sets parityErr.
- R7: A stop bit sampled as 0 sets frameErr. If every bit of the frame, from start bit through stop bit, is 0, breakInt is also set.
- R8: A commit while dataReady is set, with no rdData in that cycle, sets overrun, and the new character replaces the old one. A commit in the same cycle as rdData leaves dataReady at 1 and does not set overrun.
- R9: rdData clears dataReady, and rdStatus clears overrun, parityErr, frameErr and breakInt. When a flag is set and cleared in the same cycle, the set wins.
- R10: rxReq is a one-cycle pulse on each 0-to-1 change of dataReady while ierRx = 1. It stays 0 while ierRx = 0.
- R11: errReq is 1 exactly while ierErr = 1 and at least one of the four error flags is set.
- R12: Sampling realigns to each start edge, so back-to-back frames from a sender running about 2% fast are still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| tick | input | 1 | Oversample enable, 16 per bit period |
| cfgLen | input | 2 | Character length select, 5 to 8 bits |
| cfgParEn | input | 1 | Parity bit present |
| cfgParOdd | input | 1 | Odd parity when 1, even when 0 |
| rdData | input | 1 | Read strobe for the holding register |
| rdStatus | input | 1 | Read strobe for the error flags |
| ierRx | input | 1 | Enable for the receive request |
| ierErr | input | 1 | Enable for the error request |
| rxData | output | DATA_W | Holding register |
| dataReady | output | 1 | Unread character present |
| overrun | output | 1 | Character lost to a newer one |
| parityErr | output | 1 | Parity mismatch seen |
| frameErr | output | 1 | Stop bit sampled as 0 |
| breakInt | output | 1 | Whole frame sampled as 0 |
| rxReq | output | 1 | Receive request pulse |
| errReq | output | 1 | Error request level |

## Verification
Two pairs of functions can meet in one cycle. A character commit can land in the same cycle as rdData, and a commit that sets overrun can land in the same cycle as rdStatus. The bench first measures the commit edge of a reference frame and checks it against the R5 formula. It then replays frames and drives a strobe high at exactly that edge. It expects dataReady to stay set with no overrun in the first case, and overrun to survive the clear in the second.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrAcc;     // new frame opened
    logic decided;    // a bit value was voted this cycle
    logic bitVal;     // voted value
    logic shiftData;  // voted bit is a data bit
    logic capPar;     // voted bit is the parity bit
    logic commit;     // voted bit is the stop bit
  } rxStrobe_t;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       tick,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  output rxStrobe_t  strobe
);
  localparam int CNT_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MID     = OSR / 2;     // zero-based index of the 9th sample
  localparam int MIN_LEN = DATA_W - 3;

  rxState_t         state;
  logic [1:0]       rxSync;
  logic             rxPrev;
  logic [CNT_W-1:0] sampCnt;
  logic [1:0]       win;
  logic [IDX_W-1:0] bitIdx;

  logic rxS, fall, atMid, atEnd, maj;
  logic [IDX_W-1:0] lastIdx;

  assign rxS     = rxSync[1];
  assign fall    = (state == ST_IDLE) && rxPrev && !rxS;
  assign atMid   = tick && (sampCnt == CNT_W'(MID));
  assign atEnd   = tick && (sampCnt == CNT_W'(OSR - 1));
  assign maj     = (win[1] & win[0]) | (win[1] & rxS) | (win[0] & rxS);
  assign lastIdx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfgLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rxSync  <= 2'b11;
      rxPrev  <= 1'b1;
      sampCnt <= '0;
      win     <= 2'b11;
      bitIdx  <= '0;
    end else begin
      rxSync <= {rxSync[0], rxIn};
      rxPrev <= rxS;
      if (fall) begin
        state   <= ST_START;
        sampCnt <= '0;
        bitIdx  <= '0;
      end else if (state != ST_IDLE && tick) begin
        sampCnt <= atEnd ? '0 : sampCnt + CNT_W'(1);
        win     <= {win[0], rxS};
        if (atMid && ((state == ST_START && maj) || state == ST_STOP)) begin
          state <= ST_IDLE;
        end else if (atEnd) begin
          case (state)
            ST_START: state <= ST_DATA;
            ST_DATA:
              if (bitIdx == lastIdx) state <= cfgParEn ? ST_PAR : ST_STOP;
              else bitIdx <= bitIdx + IDX_W'(1);
            ST_PAR:   state <= ST_STOP;
            default:  ;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.clrAcc = fall;
    if (atMid && state != ST_IDLE) begin
      strobe.decided   = 1'b1;
      strobe.bitVal    = maj;
      strobe.shiftData = (state == ST_DATA);
      strobe.capPar    = (state == ST_PAR);
      strobe.commit    = (state == ST_STOP);
    end
  end

endmodule

// File: rtl/rxs_dpath.sv
module rxs_dpath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              rdData,
  input  logic              rdStatus,
  input  logic              ierRx,
  input  logic              ierErr,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              overrun,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakInt,
  output logic              rxReq,
  output logic              errReq
);
  localparam int SPAN = 3;  // longest minus shortest length

  logic [DATA_W-1:0] shiftR, aligned;
  logic parAcc, parBit, zeroAll, drPrev;
  logic parBad, stopBad;

  assign aligned = shiftR >> (2'(SPAN) - cfgLen);
  assign parBad  = cfgParEn && (parAcc ^ parBit ^ cfgParOdd);
  assign stopBad = !strobe.bitVal;

  // Frame accumulation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftR  <= '0;
      parAcc  <= 1'b0;
      parBit  <= 1'b0;
      zeroAll <= 1'b1;
    end else if (strobe.clrAcc) begin
      parAcc  <= 1'b0;
      zeroAll <= 1'b1;
    end else if (strobe.decided) begin
      zeroAll <= zeroAll & ~strobe.bitVal;
      if (strobe.shiftData) begin
        shiftR <= {strobe.bitVal, shiftR[DATA_W-1:1]};
        parAcc <= parAcc ^ strobe.bitVal;
      end
      if (strobe.capPar) parBit <= strobe.bitVal;
    end
  end

  // Holding register and status, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakInt  <= 1'b0;
      drPrev    <= 1'b0;
    end else begin
      drPrev <= dataReady;
      if (strobe.commit) rxData <= aligned;

      if (strobe.commit)  dataReady <= 1'b1;
      else if (rdData)    dataReady <= 1'b0;

      if (strobe.commit && dataReady && !rdData) overrun <= 1'b1;
      else if (rdStatus)                         overrun <= 1'b0;

      if (strobe.commit && parBad) parityErr <= 1'b1;
      else if (rdStatus)           parityErr <= 1'b0;

      if (strobe.commit && stopBad) frameErr <= 1'b1;
      else if (rdStatus)            frameErr <= 1'b0;

      if (strobe.commit && stopBad && zeroAll) breakInt <= 1'b1;
      else if (rdStatus)                       breakInt <= 1'b0;
    end
  end

  assign rxReq  = ierRx && dataReady && !drPrev;
  assign errReq = ierErr && (overrun || parityErr || frameErr || breakInt);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxs_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              tick,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              rdData,
  input  logic              rdStatus,
  input  logic              ierRx,
  input  logic              ierErr,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              overrun,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakInt,
  output logic              rxReq,
  output logic              errReq
);
  rxStrobe_t strobe;

  rxs_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .tick(tick),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .strobe(strobe)
  );

  rxs_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .rdData(rdData), .rdStatus(rdStatus), .ierRx(ierRx), .ierErr(ierErr),
    .rxData(rxData), .dataReady(dataReady), .overrun(overrun),
    .parityErr(parityErr), .frameErr(frameErr), .breakInt(breakInt),
    .rxReq(rxReq), .errReq(errReq)
  );

endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdData,
  input logic              rdStatus,
  input logic              ierRx,
  input logic              ierErr,
  input logic [DATA_W-1:0] rxData,
  input logic              dataReady,
  input logic              overrun,
  input logic              parityErr,
  input logic              frameErr,
  input logic              breakInt,
  input logic              rxReq,
  input logic              errReq
);

  // R10
  rx_req_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReq |-> (dataReady && ierRx));

  // R7
  break_has_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakInt |-> frameErr);

  // R8
  overrun_needs_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(dataReady) && dataReady));

  // R9
  parity_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parityErr) |-> $past(rdStatus));

  // R9
  ready_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(rdData));

  // R11
  err_req_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReq |-> ierErr);

  // R4
  data_changes_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> dataReady);

endmodule

bind uart_rx_status rxs_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .rdStatus(rdStatus),
  .ierRx(ierRx), .ierErr(ierErr), .rxData(rxData), .dataReady(dataReady),
  .overrun(overrun), .parityErr(parityErr), .frameErr(frameErr),
  .breakInt(breakInt), .rxReq(rxReq), .errReq(errReq)
);

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic tick = 1'b0;
  logic [1:0] cfgLen = 2'b11;
  logic cfgParEn = 1'b0, cfgParOdd = 1'b0;
  logic rdData = 1'b0, rdStatus = 1'b0;
  logic ierRx = 1'b1, ierErr = 1'b1;
  logic [7:0] rxData;
  logic dataReady, overrun, parityErr, frameErr, breakInt, rxReq, errReq;

  int checks = 0, fails = 0, reqCount = 0, cyc = 0;
  int tickDiv = 1, tickCnt = 0, bitCyc = 16;
  logic prevDr = 1'b0;

  // Behavioural model of the visible state
  logic [7:0] expData = 8'h00;
  bit expDR = 0, expOE = 0, expPE = 0, expFE = 0, expBI = 0;

  uart_rx_status uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .tick(tick), .cfgLen(cfgLen),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .rdData(rdData),
    .rdStatus(rdStatus), .ierRx(ierRx), .ierErr(ierErr), .rxData(rxData),
    .dataReady(dataReady), .overrun(overrun), .parityErr(parityErr),
    .frameErr(frameErr), .breakInt(breakInt), .rxReq(rxReq), .errReq(errReq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (tickCnt >= tickDiv - 1) tickCnt = 0; else tickCnt++;
    tick = (tickCnt == 0);
  end

  // Every-clock comparison of the request outputs
  always @(negedge clk) begin
    if (rstN) begin
      check("R10 rxReq", rxReq, ierRx && dataReady && !prevDr);
      check("R11 errReq", errReq, ierErr && (overrun || parityErr || frameErr || breakInt));
      if (rxReq) reqCount++;
    end
    prevDr = dataReady;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finishRun();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compareAll(input string req);
    check({req, " data"}, rxData, expData);
    check({req, " ready"}, dataReady, expDR);
    check({req, " overrun"}, overrun, expOE);
    check({req, " parity"}, parityErr, expPE);
    check({req, " frame"}, frameErr, expFE);
    check({req, " break"}, breakInt, expBI);
  endtask

  task automatic modelCommit(input logic [7:0] d, input bit pe, input bit fe,
                             input bit bi, input bit rdSame, input bit stSame);
    bit newOE;
    newOE = expDR && !rdSame;
    if (stSame) begin expOE = 0; expPE = 0; expFE = 0; expBI = 0; end
    expOE |= newOE; expPE |= pe; expFE |= fe; expBI |= bi;
    expDR = 1; expData = d;
  endtask

  task automatic pulseRd();
    rdData = 1; @(negedge clk); rdData = 0; expDR = 0;
  endtask

  task automatic pulseSt();
    rdStatus = 1; @(negedge clk); rdStatus = 0;
    expOE = 0; expPE = 0; expFE = 0; expBI = 0;
  endtask

  // Drives one frame; cycles gLo..gHi of bit slot gBit are inverted
  task automatic sendFrame(input logic [7:0] d, input int gBit, input int gLo,
                           input int gHi, input bit badPar, input bit stopV);
    int len, nb;
    logic [7:0] dm;
    logic par, v;
    len = 5 + int'(cfgLen);
    dm  = d & 8'((1 << len) - 1);
    par = (cfgParOdd ? ~^dm : ^dm) ^ badPar;
    nb  = 2 + len + (cfgParEn ? 1 : 0);
    for (int b = 0; b < nb; b++) begin
      if (b == 0) v = 1'b0;
      else if (b <= len) v = dm[b-1];
      else if (cfgParEn && b == len + 1) v = par;
      else v = stopV;
      for (int j = 1; j <= bitCyc; j++) begin
        rxIn = (b == gBit && j >= gLo && j <= gHi) ? ~v : v;
        @(negedge clk);
      end
    end
    rxIn = 1'b1;
  endtask

  initial begin
    int n, r0, got;
    logic [7:0] q[$];
    logic [7:0] want[3];
    want[0] = 8'h3C; want[1] = 8'hC3; want[2] = 8'h5A;

    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    compareAll("R1");
    check("R1 rxReq", rxReq, 0);
    check("R1 errReq", errReq, 0);

    // R5 commit edge, R4 bit order, R10 request
    n = 0;
    fork
      sendFrame(8'hA5, -1, 0, 0, 0, 1);
      begin
        while (!dataReady && n < 1000) begin @(negedge clk); n++; end
      end
    join
    check("R5 commit edge", n, 12 + 16 * (1 + 8 + 0));
    modelCommit(8'hA5, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R4");
    check("R10 pulse count", reqCount, 1);
    pulseRd();
    compareAll("R9 read data");

    // R2 short low pulse is dropped
    rxIn = 1'b0; idle(4); rxIn = 1'b1; idle(60);
    compareAll("R2 glitch start");

    // R3 majority vote
    sendFrame(8'h00, 3, 9, 9, 0, 1);
    modelCommit(8'h00, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R3 one sample flipped");
    pulseRd();
    sendFrame(8'h00, 3, 8, 9, 0, 1);
    modelCommit(8'h04, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R3 two samples flipped");
    pulseRd();

    // R4 / R6 five-bit characters with parity
    cfgLen = 2'b00; cfgParEn = 1'b1; cfgParOdd = 1'b0;
    idle(4);
    sendFrame(8'h1B, -1, 0, 0, 0, 1);
    modelCommit(8'h1B, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R6 even ok");
    pulseRd();
    sendFrame(8'h1B, -1, 0, 0, 1, 1);
    modelCommit(8'h1B, 1, 0, 0, 0, 0);
    idle(4);
    compareAll("R6 even bad");
    check("R11 errReq on parity", errReq, 1);
    pulseSt();
    compareAll("R9 read status");
    pulseRd();
    cfgParOdd = 1'b1;
    sendFrame(8'h0E, -1, 0, 0, 0, 1);
    modelCommit(8'h0E, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R6 odd ok");
    pulseRd();

    // R7 break and framing
    cfgLen = 2'b11; cfgParEn = 1'b0; cfgParOdd = 1'b0;
    idle(4);
    sendFrame(8'h00, -1, 0, 0, 0, 0);
    modelCommit(8'h00, 0, 1, 1, 0, 0);
    idle(8);
    compareAll("R7 break");
    pulseSt(); pulseRd(); idle(4);
    sendFrame(8'h81, -1, 0, 0, 0, 0);
    modelCommit(8'h81, 0, 1, 0, 0, 0);
    idle(8);
    compareAll("R7 framing only");
    pulseSt(); pulseRd(); idle(4);

    // R8 overrun
    sendFrame(8'h11, -1, 0, 0, 0, 1);
    modelCommit(8'h11, 0, 0, 0, 0, 0);
    sendFrame(8'h22, -1, 0, 0, 0, 1);
    modelCommit(8'h22, 0, 0, 0, 0, 0);
    idle(4);
    compareAll("R8 overrun");
    pulseSt();

    // R8 commit and data read in the same cycle
    fork
      sendFrame(8'h33, -1, 0, 0, 0, 1);
      begin repeat (155) @(negedge clk); rdData = 1; @(negedge clk); rdData = 0; end
    join
    modelCommit(8'h33, 0, 0, 0, 1, 0);
    idle(4);
    compareAll("R8 read at commit");

    // R9 overrun set while status read in the same cycle
    fork
      sendFrame(8'h44, -1, 0, 0, 0, 1);
      begin repeat (155) @(negedge clk); rdStatus = 1; @(negedge clk); rdStatus = 0; end
    join
    modelCommit(8'h44, 0, 0, 0, 0, 1);
    idle(4);
    compareAll("R9 set wins over clear");
    pulseSt(); pulseRd();

    // R10 / R11 enables off
    ierRx = 1'b0; r0 = reqCount;
    sendFrame(8'h55, -1, 0, 0, 0, 1);
    modelCommit(8'h55, 0, 0, 0, 0, 0);
    idle(4);
    check("R10 no pulse when disabled", reqCount, r0);
    compareAll("R10 data");
    pulseRd();
    ierErr = 1'b0;
    sendFrame(8'h0F, -1, 0, 0, 0, 0);
    modelCommit(8'h0F, 0, 1, 0, 0, 0);
    idle(8);
    check("R11 errReq masked", errReq, 0);
    compareAll("R11 flags");
    pulseSt(); pulseRd();
    ierRx = 1'b1; ierErr = 1'b1;

    // R12 back-to-back frames from a fast sender
    tickDiv = 3; bitCyc = 47;
    idle(6);
    got = 0;
    fork
      begin
        for (int k = 0; k < 3; k++) sendFrame(want[k], -1, 0, 0, 0, 1);
      end
      begin
        for (int t = 0; t < 3000 && got < 3; t++) begin
          @(negedge clk);
          if (dataReady) begin
            q.push_back(rxData); got++;
            rdData = 1; @(negedge clk); rdData = 0;
          end
        end
      end
    join
    check("R12 frame count", got, 3);
    for (int k = 0; k < 3; k++)
      check("R12 frame data", (k < q.size()) ? int'(q[k]) : -1, want[k]);
    expData = want[2]; expDR = 0;
    idle(4);
    compareAll("R12 end state");
    tickDiv = 1; bitCyc = 16;

    idle(4);
    finishRun();
  end

endmodule